// File: doc/BRIEF.md
# Compare Match Timer

A multi-channel compare-match timer reached through a simple synchronous register bus. Each channel owns an up-counter that advances on ticks from its own prescaler, a compare register, and a control/status word. When a counter tick finds the counter equal to the compare value, the channel latches a match flag. In periodic mode the counter then returns to zero. In free-running mode it keeps counting and latches an overflow flag when it wraps past all ones. A match flag can drive the channel's interrupt line, and the line stays high until software clears the flag.

A single start/stop word holds one run bit per channel. The bit position is the channel index. Counter writes cross a three-cycle settling path, and the channel reports that with a read-only busy bit. Counter writes that arrive while the path is busy are dropped. Control/status writes take effect two cycles after the bus write. Status flags are cleared by writing zero to them; writing one leaves them as they are.

Top module: `match_timer`

## Requirements
- R1: After reset every counter reads 0, every compare register reads all ones, every control/status word reads 0, the start/stop word reads 0 and all interrupt lines are low.
- R2: Bit i of the start/stop word at byte address 0x00 runs channel i while set. The word reads back as written. A stopped channel's counter holds its value and does not affect other channels.
- R3: The clock-select field (control bits 2:0) advances the counter once every 8, 32, 128 or 1 clock cycles for codes 4, 5, 6 and 7. The first increment lands exactly one divided period after the start write. Codes 0 to 3 never advance the counter.
- R4: In periodic mode (control bit 8 = 1) the counter runs from 0 up to and including the compare value, then returns to 0, so a period is compare + 1 ticks.
- R5: In free-running mode (bit 8 = 0) the counter passes the compare value and wraps from all ones to 0. The wrap sets the overflow flag (bit 14).
- R6: A tick at which the counter equals the compare value sets the match flag (bit 15). Writing 0 to bit 15 or bit 14 clears that flag; writing 1 leaves it unchanged.
- R7: A channel's interrupt line is high exactly while its match flag is 1, its interrupt enable (bit 7) is 1, and its routing field (bits 5:4) holds 2.
- R8: A counter write is applied 3 cycles after the bus write. From the write until then, bit 13 of the control/status word reads 1, and further counter writes are ignored.
- R9: A control/status write becomes visible in the register 2 cycles after the bus write.
- R10: Channel i's words are at byte address 0x10 + 0x10*i: control/status at +0, counter at +4 and compare at +8. Read data appears the cycle after a read. Unaligned and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | NUM_CH | Per-channel interrupt, level |

## Verification
The assertions check several properties on every cycle. A rising match flag must come from a tick at equality. A periodic tick at equality must return the counter to zero. A rising overflow flag must follow an all-ones counter. A stopped channel's counter must stay still unless a write lands. Divided prescaler ticks must never come back-to-back. A counter or control write must raise its pending indication. The bench scenarios cover what needs absolute timing and software-visible values: the exact cycle of the first tick for each divider code, the two- and three-cycle write latencies, dropped writes during busy, flag clearing rules and interrupt routing.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned PRE_W = 7;

    localparam int unsigned BIT_MF   = 15;
    localparam int unsigned BIT_OVF  = 14;
    localparam int unsigned BIT_BUSY = 13;
    localparam int unsigned BIT_PER  = 8;
    localparam int unsigned BIT_IE   = 7;

    typedef enum logic [2:0] {
        CKS_DIV8   = 3'd4,
        CKS_DIV32  = 3'd5,
        CKS_DIV128 = 3'd6,
        CKS_DIV1   = 3'd7
    } cks_e;

    typedef enum logic [1:0] {
        WORD_CTRL = 2'd0,
        WORD_CNT  = 2'd1,
        WORD_CMP  = 2'd2
    } word_e;

    localparam logic [1:0] ROUTE_IRQ = 2'd2;

    typedef struct packed {
        logic       periodic;
        logic       irq_en;
        logic [1:0] route;
        logic [2:0] cks;
    } cfg_t;

    typedef struct packed {
        logic keep_mf;
        logic keep_ovf;
        cfg_t cfg;
    } ctrl_wr_t;

    function automatic ctrl_wr_t decode_ctrl(input logic [REG_W-1:0] d);
        ctrl_wr_t r;
        r.keep_mf      = d[BIT_MF];
        r.keep_ovf     = d[BIT_OVF];
        r.cfg.periodic = d[BIT_PER];
        r.cfg.irq_en   = d[BIT_IE];
        r.cfg.route    = d[5:4];
        r.cfg.cks      = d[2:0];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] encode_ctrl(input cfg_t c, input logic mf,
                                                     input logic ovf, input logic busy);
        logic [REG_W-1:0] r;
        r           = '0;
        r[BIT_MF]   = mf;
        r[BIT_OVF]  = ovf;
        r[BIT_BUSY] = busy;
        r[BIT_PER]  = c.periodic;
        r[BIT_IE]   = c.irq_en;
        r[5:4]      = c.route;
        r[2:0]      = c.cks;
        return r;
    endfunction

    function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] cks);
        case (cks)
            CKS_DIV8:   return PRE_W'(7);
            CKS_DIV32:  return PRE_W'(31);
            CKS_DIV128: return PRE_W'(127);
            default:    return '0;
        endcase
    endfunction

    function automatic logic cks_valid(input logic [2:0] cks);
        return cks[2];
    endfunction

endpackage

// File: rtl/mt_delay_pipe.sv
module mt_delay_pipe #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         busy
);
    logic [DEPTH-1:0] vld;
    logic [W-1:0]     dat [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            for (int i = 0; i < DEPTH; i++) dat[i] <= '0;
        end else begin
            vld[0] <= in_valid;
            dat[0] <= in_data;
            for (int i = 1; i < DEPTH; i++) begin
                vld[i] <= vld[i-1];
                dat[i] <= dat[i-1];
            end
        end
    end

    assign out_valid = vld[DEPTH-1];
    assign out_data  = dat[DEPTH-1];
    assign busy      = |vld;

    assert_pipe_busy_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> busy);
endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler
    import match_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] cks,
    output logic       tick
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lim;

    assign lim = div_limit(cks);

    // Held at zero while stopped, so every start begins a fresh divided period.
    always_ff @(posedge clk) begin
        if (rst || !run)      pre <= '0;
        else if (pre >= lim)  pre <= '0;
        else                  pre <= pre + 1'b1;
    end

    assign tick = run && cks_valid(cks) && (pre == lim);

    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0) |=> !tick);
endmodule

// File: rtl/mt_channel.sv
module mt_channel
    import match_timer_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned CNT_DELAY  = 3,
    parameter int unsigned CTRL_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ctrl_wr,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0] cnt_rd,
    output logic [CNT_W-1:0] cmp_rd,
    output logic             irq
);
    localparam int unsigned CW_W = $bits(ctrl_wr_t);

    cfg_t             cfg;
    logic             mf, ovf;
    logic [CNT_W-1:0] cnt, cmp;

    ctrl_wr_t ctrl_in, ctrl_new;
    logic     ctrl_apply, ctrl_busy;

    assign ctrl_in = decode_ctrl(wdata);

    mt_delay_pipe #(.W(CW_W), .DEPTH(CTRL_DELAY)) u_ctrl_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (ctrl_wr),
        .in_data   (ctrl_in),
        .out_valid (ctrl_apply),
        .out_data  (ctrl_new),
        .busy      (ctrl_busy)
    );

    logic             cnt_take, cnt_apply, cnt_busy;
    logic [CNT_W-1:0] cnt_new;

    assign cnt_take = cnt_wr && !cnt_busy;

    mt_delay_pipe #(.W(CNT_W), .DEPTH(CNT_DELAY)) u_cnt_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (cnt_take),
        .in_data   (wdata[CNT_W-1:0]),
        .out_valid (cnt_apply),
        .out_data  (cnt_new),
        .busy      (cnt_busy)
    );

    logic tick;

    mt_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .cks  (cfg.cks),
        .tick (tick)
    );

    logic at_match, at_max, set_mf, set_ovf;

    assign at_match = (cnt == cmp);
    assign at_max   = &cnt;
    assign set_mf   = tick && !cnt_apply && at_match;
    assign set_ovf  = tick && !cnt_apply && at_max && !(cfg.periodic && at_match);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            cmp <= '1;
            cfg <= '0;
            mf  <= 1'b0;
            ovf <= 1'b0;
        end else begin
            if (cmp_wr) cmp <= wdata[CNT_W-1:0];

            if (cnt_apply)                      cnt <= cnt_new;
            else if (tick && cfg.periodic && at_match) cnt <= '0;
            else if (tick)                      cnt <= cnt + 1'b1;

            if (ctrl_apply) begin
                cfg <= ctrl_new.cfg;
                mf  <= set_mf  || (mf  && ctrl_new.keep_mf);
                ovf <= set_ovf || (ovf && ctrl_new.keep_ovf);
            end else begin
                mf  <= mf  || set_mf;
                ovf <= ovf || set_ovf;
            end
        end
    end

    assign ctrl_rd = encode_ctrl(cfg, mf, ovf, cnt_busy);
    assign cnt_rd  = cnt;
    assign cmp_rd  = cmp;
    assign irq     = mf && cfg.irq_en && (cfg.route == ROUTE_IRQ);

    assert_match_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mf) |-> $past(tick && (cnt == cmp)));

    assert_periodic_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && cfg.periodic && (cnt == cmp) && !cnt_apply) |=> (cnt == '0));

    assert_overflow_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(&cnt));

    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_apply) |=> $stable(cnt));

    assert_ctrl_pending_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> ctrl_busy);
endmodule

// File: rtl/match_timer.sv
module match_timer
    import match_timer_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int unsigned BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    logic [1:0]       word;
    logic             aligned, hit_ss;
    logic [NUM_CH-1:0] run, hit_ch;

    assign blk     = bus_addr[ADDR_W-1:4];
    assign word    = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign hit_ss  = bus_en && aligned && (blk == '0) && (word == 2'd0);

    always_ff @(posedge clk) begin
        if (rst)                  run <= '0;
        else if (hit_ss && bus_we) run <= bus_wdata[NUM_CH-1:0];
    end

    logic [REG_W-1:0] ctrl_rd_a [NUM_CH];
    logic [CNT_W-1:0] cnt_rd_a  [NUM_CH];
    logic [CNT_W-1:0] cmp_rd_a  [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign hit_ch[i] = bus_en && aligned && (blk == BLK_W'(i + 1)) && (word != 2'd3);

        mt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .run     (run[i]),
            .ctrl_wr (hit_ch[i] && bus_we && (word == WORD_CTRL)),
            .cnt_wr  (hit_ch[i] && bus_we && (word == WORD_CNT)),
            .cmp_wr  (hit_ch[i] && bus_we && (word == WORD_CMP)),
            .wdata   (bus_wdata),
            .ctrl_rd (ctrl_rd_a[i]),
            .cnt_rd  (cnt_rd_a[i]),
            .cmp_rd  (cmp_rd_a[i]),
            .irq     (irq[i])
        );
    end

    logic [REG_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (hit_ss) rd_mux = REG_W'(run);
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_ch[i]) begin
                case (word)
                    WORD_CTRL: rd_mux = ctrl_rd_a[i];
                    WORD_CNT:  rd_mux = REG_W'(cnt_rd_a[i]);
                    WORD_CMP:  rd_mux = REG_W'(cmp_rd_a[i]);
                    default:   rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  bus_rdata <= '0;
        else if (bus_en && !bus_we) bus_rdata <= rd_mux;
    end

    assert_run_write_R2: assert property (@(posedge clk) disable iff (rst)
        (hit_ss && bus_we) |=> (run == $past(bus_wdata[NUM_CH-1:0])));
endmodule

// File: tb/match_timer_tb.sv
`timescale 1ns/1ps
module match_timer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [1:0]  irq;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    longint      cyc = 0;
    longint      w_edge = 0;
    longint      cap_edge = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    match_timer #(.NUM_CH(2), .CNT_W(32), .ADDR_W(8)) u_dut (
        .clk (clk), .rst (rst), .bus_en (bus_en), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        w_edge = cyc;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
        cap_edge = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int div_of(input int code);
        case (code)
            4: return 8;
            5: return 32;
            6: return 128;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] exp_count(input longint t, input int n, input longint c,
                                              input bit per, input logic [31:0] s);
        longint ticks;
        ticks = t / n;
        if (per) return 32'((longint'(s) + ticks) % (c + 1));
        return 32'(longint'(s) + ticks);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0;
        void'($urandom(32'd1357));
        rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h10, v); chk("R1 ctrl reset", v, 32'h0);
        rd(8'h14, v); chk("R1 counter reset", v, 32'h0);
        rd(8'h28, v); chk("R1 compare reset", v, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R1 start/stop reset", v, 32'h0);
        chk("R1 irq reset", {30'b0, irq}, 32'h0);

        // R10 unmapped and unaligned
        rd(8'h1C, v); chk("R10 unmapped word", v, 32'h0);
        rd(8'h30, v); chk("R10 unmapped block", v, 32'h0);
        rd(8'h19, v); chk("R10 unaligned", v, 32'h0);

        // R8 counter write latency, busy bit, dropped write
        wr(8'h14, 32'd5);
        rd(8'h10, v); chk("R8 busy during write", v, 32'h0000_2000);
        wr(8'h14, 32'd9);
        idle(4);
        rd(8'h14, v); chk("R8 write while busy ignored", v, 32'd5);
        rd(8'h10, v); chk("R8 busy cleared", v, 32'h0);

        // R9 control write latency
        wr(8'h10, 32'h0000_0107);
        rd(8'h10, v); chk("R9 old value one cycle later", v, 32'h0);
        rd(8'h10, v); chk("R9 old value two cycles later", v, 32'h0);
        rd(8'h10, v); chk("R9 new value visible", v, 32'h0000_0107);

        // R3 divider codes and first tick timing
        for (int k = 4; k < 8; k++) begin
            int n;
            n = div_of(k);
            wr(8'h00, 32'h0);
            wr(8'h14, 32'h0);
            idle(4);
            wr(8'h10, 32'(k));
            idle(3);
            wr(8'h00, 32'h1);
            idle(n - 1);
            rd(8'h14, v); chk($sformatf("R3 code %0d before first tick", k), v, 32'd0);
            rd(8'h14, v); chk($sformatf("R3 code %0d first tick", k), v, 32'd1);
        end

        // R3 codes below 4 never count
        wr(8'h00, 32'h0);
        wr(8'h14, 32'h0);
        idle(4);
        wr(8'h10, 32'h3);
        idle(3);
        wr(8'h00, 32'h1);
        idle(20);
        rd(8'h14, v); chk("R3 code 3 holds", v, 32'd0);
        wr(8'h00, 32'h0);

        // R5 free-running wrap sets overflow
        wr(8'h18, 32'h100);
        wr(8'h14, 32'hFFFF_FFFC);
        idle(4);
        wr(8'h10, 32'h7);
        idle(3);
        wr(8'h00, 32'h1);
        begin
            longint ws;
            ws = w_edge;
            idle(10);
            rd(8'h14, v);
            chk("R5 counter wraps", v, exp_count(cap_edge - 1 - ws, 1, 0, 1'b0, 32'hFFFF_FFFC));
        end
        wr(8'h00, 32'h0);
        rd(8'h10, v); chk("R5 overflow flag", v, 32'h0000_4007);

        // R6 write one keeps, write zero clears
        wr(8'h10, 32'h0000_4007);
        idle(3);
        rd(8'h10, v); chk("R6 overflow kept by writing 1", v, 32'h0000_4007);
        wr(8'h10, 32'h0000_0007);
        idle(3);
        rd(8'h10, v); chk("R6 overflow cleared by writing 0", v, 32'h0000_0007);

        // R7 interrupt on channel 1, R2 independence
        wr(8'h24, 32'h0);
        idle(4);
        wr(8'h28, 32'd2);
        wr(8'h20, 32'h0000_01A7);
        idle(3);
        rd(8'h14, v0);
        wr(8'h00, 32'h2);
        idle(12);
        chk("R7 irq raised on channel 1 only", {30'b0, irq}, 32'h2);
        rd(8'h00, v); chk("R2 start/stop readback", v, 32'h2);
        rd(8'h14, v); chk("R2 stopped channel 0 holds", v, v0);
        wr(8'h00, 32'h0);
        wr(8'h20, 32'h0000_8197);
        idle(3);
        chk("R7 routing 1 masks irq", {30'b0, irq}, 32'h0);
        rd(8'h20, v); chk("R6 match flag kept", v & 32'h8000, 32'h8000);
        wr(8'h20, 32'h0000_81A7);
        idle(3);
        chk("R7 routing 2 restores irq", {30'b0, irq}, 32'h2);
        wr(8'h20, 32'h0000_01A7);
        idle(3);
        chk("R6 match flag cleared drops irq", {30'b0, irq}, 32'h0);

        // R4 periodic sequence, compare 4
        wr(8'h24, 32'h0);
        idle(4);
        wr(8'h28, 32'd4);
        wr(8'h20, 32'h0000_0107);
        idle(3);
        wr(8'h00, 32'h2);
        begin
            longint ws;
            ws = w_edge;
            for (int j = 0; j < 7; j++) begin
                rd(8'h24, v);
                chk("R4 periodic count", v, exp_count(cap_edge - 1 - ws, 1, 4, 1'b1, 32'h0));
            end
        end
        wr(8'h00, 32'h0);

        // Random configurations
        for (int it = 0; it < 10; it++) begin
            int ch, k, n, c, gap;
            bit per;
            logic [7:0] base;
            longint ws, ticks2;
            logic [31:0] ectrl;
            ch   = int'($urandom_range(0, 1));
            k    = int'($urandom_range(4, 7));
            n    = div_of(k);
            c    = int'($urandom_range(2, 60));
            per  = 1'($urandom_range(0, 1));
            gap  = int'($urandom_range(0, 300));
            base = 8'h10 + 8'(16 * ch);
            wr(8'h00, 32'h0);
            wr(base + 8'h4, 32'h0);
            idle(4);
            wr(base + 8'h8, 32'(c));
            wr(base, (32'(per) << 8) | 32'(k));
            idle(3);
            wr(8'h00, 32'h1 << ch);
            ws = w_edge;
            idle(gap);
            rd(base + 8'h4, v);
            chk(per ? "R4 random periodic count" : "R5 random free count", v,
                exp_count(cap_edge - 1 - ws, n, c, per, 32'h0));
            rd(base, v);
            ticks2 = (cap_edge - 1 - ws) / n;
            ectrl  = (32'(per) << 8) | 32'(k);
            if (ticks2 >= c + 1) ectrl = ectrl | 32'h8000;
            chk("R6 random match flag", v, ectrl);
        end
        wr(8'h00, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule